// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block sits on the read path of a byte-wide flash memory model and decides what a read returns while the memory is busy with an internal program or erase. A command front end signals each write strobe of a command sequence and marks the last strobe with a start pulse, the operation kind and bit 7 of the byte being programmed. The block checks that the sequence had the right length for that kind, then runs an internal busy timer. While the timer runs, reads from inside the valid address window carry status instead of array contents: bit 7 is a polling bit, and bit 6 flips on every successive read.

When the timer expires, a short settle window follows. In that window bit 7 already shows true array data, while bits 6:0 still repeat the previous read. After the window, reads pass array data through unchanged. Reads outside the valid address window never carry status, and they never move the toggle bit. Program and erase lengths, the settle length and the address window are parameters counted in clock cycles and words.

Top module: `flash_oper_status`

## Requirements
- R1: After reset and whenever no operation or settle window is active, `busy` is 0 and `rd_data` equals `rd_array` on all eight bits.
- R2: `op_kind` encodes 00 = program and 01, 10, 11 = sector, block and chip erase. A start is taken only when `op_start` and `cmd_strobe` are high together and the strobe count, including that cycle, is exactly 4 for a program or 6 for an erase. Any other start is ignored and `busy` stays 0.
- R3: After an accepted start, `busy` is high for exactly PROG_CYCLES clock cycles for a program and ERASE_CYCLES cycles for any erase.
- R4: During a program, an in-range read returns the inverse of `prog_msb` (as captured at the start) on bit 7.
- R5: During any erase, an in-range read returns 0 on bit 7. Once the erase and the settle window have ended, bit 7 follows the array, so an erased byte of FF reads 1.
- R6: During either operation, the first in-range read after the start returns 0 on bit 6, and each later in-range read returns the inverse of the previous one. Bits 5:0 pass `rd_array` through.
- R7: For SETTLE_CYCLES cycles after `busy` falls, an in-range read returns `rd_array[7]` on bit 7, and on bits 6:0 it returns bits 6:0 of the previous in-range read. Toggling has stopped.
- R8: Once the settle window ends, reads pass through unchanged again.
- R9: A read with `rd_addr` >= ADDR_LIMIT returns `rd_array` unchanged in every state and does not advance the toggle.
- R10: A start sequence given while `busy` is high is ignored and does not disturb the running operation. The strobe count is cleared by every `op_start`, whether or not it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_strobe | input | 1 | One pulse per write strobe of a command sequence |
| op_start | input | 1 | Marks the final strobe of a command |
| op_kind | input | 2 | Operation kind (00 program, others erase) |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| rd_strobe | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_array | input | 8 | Array data for the read address |
| rd_data | output | 8 | Byte returned to the reader |
| busy | output | 1 | High while the embedded operation runs |

## Verification
The bench goes after the toggle phase: a design that does not clear the toggle at start, or that advances it every clock, returns 1 on the first poll or skips values. It issues command sequences one strobe too short or too long, and a single strobe right after a rejected start; a design that keeps a stale count or checks only the start pulse would wrongly go busy. It reads out of range in the middle of an erase, which exposes a toggle that moves on those reads or status that leaks onto them. It also reads at the first and last settle cycles and just after them, which catches a settle window that is off by one or that drops stale bits onto true data.

// File: rtl/fos_pkg.sv
package fos_pkg;

  typedef enum logic [1:0] {
    OPK_PROG       = 2'b00,
    OPK_ERASE_SEC  = 2'b01,
    OPK_ERASE_BLK  = 2'b10,
    OPK_ERASE_CHIP = 2'b11
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SETTLE
  } fos_state_e;

  localparam int unsigned PROG_STROBES  = 4;
  localparam int unsigned ERASE_STROBES = 6;

  function automatic logic kind_is_erase(input logic [1:0] kind);
    return kind != OPK_PROG;
  endfunction

  function automatic int unsigned strobes_needed(input logic [1:0] kind);
    return kind_is_erase(kind) ? ERASE_STROBES : PROG_STROBES;
  endfunction

  function automatic int unsigned cmax3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Byte seen by a reader while an operation runs.
  function automatic logic [7:0] busy_byte(input logic erasing, input logic msb,
                                           input logic tog, input logic [7:0] arr);
    logic poll;
    poll = erasing ? 1'b0 : ~msb;
    return {poll, tog, arr[5:0]};
  endfunction

  // Byte seen during the settle window: true msb, stale low bits.
  function automatic logic [7:0] settle_byte(input logic [7:0] arr, input logic [6:0] stale);
    return {arr[7], stale};
  endfunction

endpackage

// File: rtl/fos_cmd_gate.sv
module fos_cmd_gate
  import fos_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_strobe,
  input  logic       op_start,
  input  logic [1:0] op_kind,
  input  logic       engine_busy,
  output logic       accept
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_incl;
  logic [CNT_W:0]   cnt_need;

  assign cnt_incl = {1'b0, cnt_q} + (CNT_W+1)'(cmd_strobe);
  assign cnt_need = (CNT_W+1)'(strobes_needed(op_kind));
  assign accept   = op_start & cmd_strobe & ~engine_busy & (cnt_incl == cnt_need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (op_start || engine_busy) begin
      cnt_q <= '0;
    end else if (cmd_strobe && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fos_busy_timer.sv
module fos_busy_timer
  import fos_pkg::*;
#(
  parameter int unsigned PROG_CYCLES   = 20,
  parameter int unsigned ERASE_CYCLES  = 60,
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic accept_erase,
  output logic busy,
  output logic erasing,
  output logic settling,
  output logic op_done
);
  localparam int unsigned MAX_C = cmax3(PROG_CYCLES, ERASE_CYCLES, SETTLE_CYCLES);
  localparam int unsigned TMR_W = $clog2(MAX_C + 1);
  localparam logic [TMR_W-1:0] LEN_PROG   = TMR_W'(PROG_CYCLES);
  localparam logic [TMR_W-1:0] LEN_ERASE  = TMR_W'(ERASE_CYCLES);
  localparam logic [TMR_W-1:0] LEN_SETTLE = TMR_W'(SETTLE_CYCLES);
  localparam logic [TMR_W-1:0] ONE        = TMR_W'(1);

  fos_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             last_tick;

  assign last_tick = (tmr_q == ONE);
  assign busy      = (st_q == ST_PROG) || (st_q == ST_ERASE);
  assign erasing   = (st_q == ST_ERASE);
  assign settling  = (st_q == ST_SETTLE);
  assign op_done   = busy && last_tick;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    case (st_q)
      ST_IDLE, ST_SETTLE: begin
        if (accept) begin
          st_d  = accept_erase ? ST_ERASE : ST_PROG;
          tmr_d = accept_erase ? LEN_ERASE : LEN_PROG;
        end else if (st_q == ST_SETTLE) begin
          if (last_tick) begin
            st_d  = ST_IDLE;
            tmr_d = '0;
          end else begin
            tmr_d = tmr_q - ONE;
          end
        end
      end
      default: begin
        if (last_tick) begin
          st_d  = (SETTLE_CYCLES == 0) ? ST_IDLE : ST_SETTLE;
          tmr_d = LEN_SETTLE;
        end else begin
          tmr_d = tmr_q - ONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/fos_toggle.sv
module fos_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic tog
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog <= 1'b0;
    end else if (clear) begin
      tog <= 1'b0;
    end else if (advance) begin
      tog <= ~tog;
    end
  end
endmodule

// File: rtl/flash_oper_status.sv
module flash_oper_status
  import fos_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned ADDR_LIMIT    = 32'h0007_0000,
  parameter int unsigned PROG_CYCLES   = 20,
  parameter int unsigned ERASE_CYCLES  = 60,
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_strobe,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic              prog_msb,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_array,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int unsigned CNT_W = $clog2(ERASE_STROBES + 2);
  localparam logic [ADDR_W:0] LIMIT_EXT = (ADDR_W+1)'(ADDR_LIMIT);

  logic       accept;
  logic       erasing;
  logic       settling;
  logic       op_done;
  logic       in_range;
  logic       rd_hit;
  logic       tog;
  logic       msb_q;
  logic [6:0] hold_q;

  assign in_range = ({1'b0, rd_addr} < LIMIT_EXT);
  assign rd_hit   = rd_strobe & in_range;

  fos_cmd_gate #(.CNT_W(CNT_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_strobe (cmd_strobe),
    .op_start   (op_start),
    .op_kind    (op_kind),
    .engine_busy(busy),
    .accept     (accept)
  );

  fos_busy_timer #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .accept_erase(kind_is_erase(op_kind)),
    .busy        (busy),
    .erasing     (erasing),
    .settling    (settling),
    .op_done     (op_done)
  );

  fos_toggle u_tog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .advance(rd_hit & busy),
    .tog    (tog)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (accept) msb_q <= prog_msb;
      if (rd_hit) hold_q <= rd_data[6:0];
    end
  end

  always_comb begin
    if (!in_range)     rd_data = rd_array;
    else if (busy)     rd_data = busy_byte(erasing, msb_q, tog, rd_array);
    else if (settling) rd_data = settle_byte(rd_array, hold_q);
    else               rd_data = rd_array;
  end
endmodule

// File: rtl/fos_chk.sv
module fos_chk #(
  parameter int unsigned PROG_CYCLES   = 20,
  parameter int unsigned ERASE_CYCLES  = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       cmd_strobe,
  input logic       op_start,
  input logic [1:0] op_kind,
  input logic       prog_msb,
  input logic       busy,
  input logic       settling,
  input logic       rd_strobe,
  input logic       in_range,
  input logic [7:0] rd_array,
  input logic [7:0] rd_data
);
  int unsigned len_q;
  int unsigned run_cnt;
  logic        erase_q;
  logic        msb_q;
  logic        have_prev;
  logic        last_b6;
  logic        hit;

  assign hit = rd_strobe & in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= 0;
      run_cnt   <= 0;
      erase_q   <= 1'b0;
      msb_q     <= 1'b0;
      have_prev <= 1'b0;
      last_b6   <= 1'b0;
    end else if (accept) begin
      len_q     <= (op_kind != 2'b00) ? ERASE_CYCLES : PROG_CYCLES;
      run_cnt   <= 0;
      erase_q   <= (op_kind != 2'b00);
      msb_q     <= prog_msb;
      have_prev <= 1'b0;
    end else begin
      if (busy) run_cnt <= run_cnt + 1;
      if (busy && hit) begin
        have_prev <= 1'b1;
        last_b6   <= rd_data[6];
      end
    end
  end

  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !settling) |-> (rd_data == rd_array));

  // R2
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (op_start && cmd_strobe && !busy));

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == len_q));

  // R4
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hit && !erase_q) |-> (rd_data[7] == ~msb_q));

  // R5
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hit && erase_q) |-> (rd_data[7] == 1'b0));

  // R6
  toggle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hit && !have_prev) |-> (rd_data[6] == 1'b0));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hit && have_prev) |-> (rd_data[6] != last_b6));

  // R7
  settle_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && hit) |-> (rd_data[7] == rd_array[7]));

  // R9
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !in_range) |-> (rd_data == rd_array));
endmodule

bind flash_oper_status fos_chk #(
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .cmd_strobe(cmd_strobe),
  .op_start  (op_start),
  .op_kind   (op_kind),
  .prog_msb  (prog_msb),
  .busy      (busy),
  .settling  (settling),
  .rd_strobe (rd_strobe),
  .in_range  (in_range),
  .rd_array  (rd_array),
  .rd_data   (rd_data)
);

// File: tb/flash_oper_status_tb.sv
module flash_oper_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 19;
  localparam int LIMIT      = 32'h0007_0000;
  localparam int PROG_N     = 20;
  localparam int ERASE_N    = 60;
  localparam int SETTLE_N   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_strobe = 1'b0;
  logic              op_start = 1'b0;
  logic [1:0]        op_kind = 2'b00;
  logic              prog_msb = 1'b0;
  logic              rd_strobe = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        rd_array = '0;
  logic [7:0]        rd_data;
  logic              busy;

  int   n_vec = 0;
  int   n_bad = 0;
  logic [7:0] last_hit = '0;
  logic       tog_exp = 1'b0;

  flash_oper_status #(
    .ADDR_W(ADDR_W), .ADDR_LIMIT(LIMIT), .PROG_CYCLES(PROG_N),
    .ERASE_CYCLES(ERASE_N), .SETTLE_CYCLES(SETTLE_N)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .op_start(op_start),
    .op_kind(op_kind), .prog_msb(prog_msb), .rd_strobe(rd_strobe),
    .rd_addr(rd_addr), .rd_array(rd_array), .rd_data(rd_data), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic msb, input int n);
    for (int i = 0; i < n; i++) begin
      cmd_strobe = 1'b1;
      op_start   = (i == n - 1);
      op_kind    = kind;
      prog_msb   = msb;
      @(negedge clk);
    end
    cmd_strobe = 1'b0;
    op_start   = 1'b0;
  endtask

  task automatic rd(input string req, input logic [ADDR_W-1:0] addr,
                    input logic [7:0] arr, input logic [7:0] exp);
    rd_strobe = 1'b1;
    rd_addr   = addr;
    rd_array  = arr;
    #1;
    check(req, rd_data, exp);
    if (int'(addr) < LIMIT) last_hit = exp;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  // in-range read during an operation: expected from the requirements
  task automatic poll(input string req, input logic erase, input logic msb,
                      input logic [7:0] arr);
    rd(req, 19'h00123, arr, {erase ? 1'b0 : ~msb, tog_exp, arr[5:0]});
    tog_exp = ~tog_exp;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_quiet();
    int n;
    count_busy(n);
    repeat (SETTLE_N + 1) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 busy after reset", {7'd0, busy}, 8'h00);
    rd("R1 idle pass", 19'h00010, 8'h3C, 8'h3C);
    rd("R1 idle pass", 19'h00011, 8'h81, 8'h81);
  endtask

  task automatic t_lengths();
    int n;
    issue(2'b00, 1'b0, 4);
    count_busy(n);
    check("R3 program length", 8'(n), 8'(PROG_N));
    repeat (SETTLE_N + 1) @(negedge clk);
    issue(2'b01, 1'b0, 6);
    count_busy(n);
    check("R3 erase length", 8'(n), 8'(ERASE_N));
    repeat (SETTLE_N + 1) @(negedge clk);
  endtask

  task automatic t_program(input logic msb);
    int n;
    issue(2'b00, msb, 4);
    tog_exp = 1'b0;
    poll("R4 R6 program poll", 1'b0, msb, 8'h15);
    poll("R4 R6 program poll", 1'b0, msb, 8'hE7);
    poll("R4 R6 program poll", 1'b0, msb, 8'h6A);
    count_busy(n);
    rd("R7 first settle read", 19'h00124, 8'hAC, {1'b1, last_hit[6:0]});
    repeat (SETTLE_N - 2) @(negedge clk);
    rd("R7 last settle read", 19'h00125, 8'h2C, {1'b0, last_hit[6:0]});
    rd("R8 after settle", 19'h00126, 8'h5B, 8'h5B);
  endtask

  task automatic t_erase();
    issue(2'b11, 1'b1, 6);
    tog_exp = 1'b0;
    for (int i = 0; i < 4; i++) poll("R5 R6 erase poll", 1'b1, 1'b0, 8'hFF);
    wait_quiet();
    rd("R5 erased byte reads 1 on bit 7", 19'h00200, 8'hFF, 8'hFF);
  endtask

  task automatic t_bad_counts();
    issue(2'b00, 1'b0, 3);
    check("R2 program with 3 strobes", {7'd0, busy}, 8'h00);
    issue(2'b00, 1'b0, 1);
    check("R10 count cleared by start", {7'd0, busy}, 8'h00);
    issue(2'b10, 1'b0, 5);
    check("R2 erase with 5 strobes", {7'd0, busy}, 8'h00);
    issue(2'b01, 1'b0, 4);
    check("R2 erase with 4 strobes", {7'd0, busy}, 8'h00);
    issue(2'b00, 1'b0, 6);
    check("R2 program with 6 strobes", {7'd0, busy}, 8'h00);
    issue(2'b10, 1'b0, 7);
    check("R2 erase with 7 strobes", {7'd0, busy}, 8'h00);
    issue(2'b10, 1'b0, 6);
    check("R2 block erase with 6 strobes", {7'd0, busy}, 8'h01);
    wait_quiet();
  endtask

  task automatic t_start_while_busy();
    int n;
    issue(2'b00, 1'b1, 4);
    tog_exp = 1'b0;
    poll("R10 program before restart", 1'b0, 1'b1, 8'h00);
    issue(2'b01, 1'b0, 6);
    poll("R10 program after ignored erase", 1'b0, 1'b1, 8'h00);
    count_busy(n);
    check("R10 R3 length unchanged", 8'(n), 8'(PROG_N - 8));
    repeat (SETTLE_N + 1) @(negedge clk);
  endtask

  task automatic t_out_of_range();
    issue(2'b01, 1'b0, 6);
    tog_exp = 1'b0;
    poll("R6 erase poll", 1'b1, 1'b0, 8'h00);
    rd("R9 out of range busy", 19'(LIMIT), 8'hA5, 8'hA5);
    rd("R9 out of range busy", '1, 8'hC0, 8'hC0);
    poll("R9 toggle not advanced", 1'b1, 1'b0, 8'h00);
    wait_quiet();
    rd("R9 out of range idle", 19'h7FFFE, 8'h96, 8'h96);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_program(1'b0);
    t_program(1'b1);
    t_erase();
    t_bad_counts();
    t_start_while_busy();
    t_out_of_range();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule